// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers the interrupt events of a serial bus controller into one active-low request line. Eight sources feed it: an error source, a bus wakeup source, three transmit buffers, two receive buffers and a message error source. Each source has one bit in an enable register and one bit at the same position in a flag register. Upstream logic sends each event as a one-cycle set pulse. For each source it also sends a level that stays high while the cause of the event is still present. While that level is high, the host cannot clear the flag.

The host reaches both registers through a small register port. A plain write replaces the whole selected register. A bit-modify write changes only the bits selected by a mask, so the host can clear one flag without disturbing another flag that an event raises during the same access. The host may also write a 1 into a flag to raise a software interrupt. Alongside the request line, the block gives a 3-bit code that names the most urgent enabled pending source. A wakeup event also raises a one-cycle request to leave sleep. The surrounding controller uses that request to resume in listen-only operation.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, both registers read 0, `irqN` is 1 and `irqCode` is 0.
- R2: `irqN` is 0 exactly when at least one flag bit and the enable bit at the same position are both 1. The output follows register changes in the cycle that they take effect.
- R3: A set pulse on `evtSet[i]` makes flag bit i read 1 from the next cycle. This happens whether or not enable bit i is set.
- R4: While `evtCond[i]` is 1, a host write of 0 to flag bit i leaves it at 1. Once `evtCond[i]` is 0, the same write clears the bit.
- R5: A host write of 1 to a flag bit sets it. If the matching enable bit is set, `irqN` goes low.
- R6: With `regModify` = 1, a write changes only the bits where `regMask` is 1 and leaves the other bits unchanged. With `regModify` = 0, `regMask` is ignored and all eight bits take `regData`.
- R7: Bit positions are: 0 error, 1 wakeup, 2 transmit 0, 3 transmit 1, 4 transmit 2, 5 receive 0, 6 receive 1, 7 message error. `irqCode` is the lowest pending enabled position among bits 0 to 6, plus one: 1 error, 2 wakeup, 3 to 5 transmit 0 to 2, 6 and 7 receive 0 and 1. The value 0 means none of these is pending. Once the top source is cleared, the code moves to the next pending enabled source in the same cycle.
- R8: Message error (bit 7), when it is set and enabled, drives `irqN` low. It never changes `irqCode`.
- R9: If a set pulse on `evtSet[i]` comes in the same cycle as a host write that clears flag bit i, the bit ends up at 1.
- R10: A set pulse on `evtSet[1]` (wakeup) makes `wakeReq` 1 for exactly the following cycle.
- R11: `regSel` = 0 selects the enable register and `regSel` = 1 selects the flag register, for both writes and readback. `regRdData` shows the selected register without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtSet | input | 8 | One-cycle event pulses, one per source |
| evtCond | input | 8 | Levels that are high while a source's cause is still present |
| regWrEn | input | 1 | Register write strobe |
| regModify | input | 1 | 1 = masked bit-modify write, 0 = plain write |
| regSel | input | 1 | 0 = enable register, 1 = flag register |
| regMask | input | 8 | Bit-modify mask |
| regData | input | 8 | Write data |
| regRdData | output | 8 | Contents of the selected register |
| irqN | output | 1 | Interrupt request, active low |
| irqCode | output | 3 | Code of the most urgent enabled pending source |
| wakeReq | output | 1 | One-cycle request to leave sleep |

## Verification
The bench builds the block with its default parameters: eight sources and a 3-bit code. With these, every code value from 0 to 7 can be reached, and message error occupies the one source slot that lies outside the code. Directed steps walk the code down through every priority level. Further directed steps show that message error alone pulls the request low while the code stays 0. Others check that a live condition blocks a clear and that an event wins against a clear in the same cycle. Random traffic then mixes events, condition levels, plain writes and masked writes on both registers, and the bench compares every output against its own register model after each cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC   = 8;
  localparam int CODED_SRC = NUM_SRC - 1;
  localparam int CODE_W    = $clog2(NUM_SRC);

  typedef enum logic [CODE_W-1:0] {
    SRC_ERR  = 3'd0,
    SRC_WAKE = 3'd1,
    SRC_TX0  = 3'd2,
    SRC_TX1  = 3'd3,
    SRC_TX2  = 3'd4,
    SRC_RX0  = 3'd5,
    SRC_RX1  = 3'd6,
    SRC_MERR = 3'd7
  } srcIdx_e;

  // Strobes from the register control to the datapath
  typedef struct packed {
    logic               enWr;
    logic               flagWr;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/irq_regctrl.sv
module irq_regctrl
  import irq_pkg::*;
(
  input  logic               regWrEn,
  input  logic               regModify,
  input  logic               regSel,
  input  logic [NUM_SRC-1:0] regMask,
  input  logic [NUM_SRC-1:0] regData,
  output regStrobe_t         strb
);
  always_comb begin
    strb.enWr   = regWrEn && !regSel;
    strb.flagWr = regWrEn && regSel;
    // A plain write touches every bit; a bit-modify write only the masked ones
    strb.mask   = regModify ? regMask : {NUM_SRC{1'b1}};
    strb.data   = regData;
  end
endmodule

// File: rtl/irq_prienc.sv
module irq_prienc #(
  parameter int N  = 7,
  parameter int CW = 3
) (
  input  logic [N-1:0]  pend,
  output logic [CW-1:0] code
);
  // Lowest pending index wins; index i reports as i+1, zero means idle
  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) code = CW'(i + 1);
    end
  end
endmodule

// File: rtl/irq_flagpath.sv
module irq_flagpath
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [NUM_SRC-1:0] evtSet,
  input  logic [NUM_SRC-1:0] evtCond,
  input  logic               regSel,
  output logic [NUM_SRC-1:0] enReg,
  output logic [NUM_SRC-1:0] flagReg,
  output logic [NUM_SRC-1:0] rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          enReg <= '0;
    else if (strb.enWr) enReg <= (enReg & ~strb.mask) | (strb.data & strb.mask);
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        flagReg[g] <= 1'b0;
      else if (evtSet[g])
        flagReg[g] <= 1'b1;                       // event wins over a clear
      else if (strb.flagWr && strb.mask[g])
        flagReg[g] <= strb.data[g] | evtCond[g];  // live condition blocks a clear
    end
  end

  assign rdData = regSel ? flagReg : enReg;

  // R9: a pulse always leaves its flag set
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagReg & $past(evtSet)) == $past(evtSet)));

  // R4: a set flag with its condition present stays set
  p_cond_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagReg & $past(flagReg & evtCond)) == $past(flagReg & evtCond)));

  // R6: unmasked bits are untouched by a flag write
  p_unmasked_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagWr |=> (((flagReg ^ $past(flagReg)) & ~$past(strb.mask) & ~$past(evtSet)) == '0));

  p_en_unmasked_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.enWr |=> (((enReg ^ $past(enReg)) & ~$past(strb.mask)) == '0));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtSet,
  input  logic [NUM_SRC-1:0] evtCond,
  input  logic               regWrEn,
  input  logic               regModify,
  input  logic               regSel,
  input  logic [NUM_SRC-1:0] regMask,
  input  logic [NUM_SRC-1:0] regData,
  output logic [NUM_SRC-1:0] regRdData,
  output logic               irqN,
  output logic [CODE_W-1:0]  irqCode,
  output logic               wakeReq
);
  regStrobe_t         strb;
  logic [NUM_SRC-1:0] enReg;
  logic [NUM_SRC-1:0] flagReg;
  logic [NUM_SRC-1:0] pending;

  irq_regctrl i_ctrl (
    .regWrEn(regWrEn), .regModify(regModify), .regSel(regSel),
    .regMask(regMask), .regData(regData), .strb(strb)
  );

  irq_flagpath i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .evtSet(evtSet), .evtCond(evtCond),
    .regSel(regSel), .enReg(enReg), .flagReg(flagReg), .rdData(regRdData)
  );

  assign pending = flagReg & enReg;
  assign irqN    = ~|pending;

  // The top slot (message error) drives the request line only
  irq_prienc #(.N(CODED_SRC), .CW(CODE_W)) i_enc (
    .pend(pending[CODED_SRC-1:0]), .code(irqCode)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeReq <= 1'b0;
    else       wakeReq <= evtSet[SRC_WAKE];
  end

  // R2: an enabled event pulls the request low next cycle
  p_irq_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((|(evtSet & enReg)) && !regWrEn) |=> !irqN);

  // R7: a nonzero code names a source that is pending and enabled
  p_code_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqCode != '0) |-> (flagReg[irqCode - CODE_W'(1)] && enReg[irqCode - CODE_W'(1)] && !irqN));

  // R10: wake request follows the wakeup pulse
  p_wake_r10: assert property (@(posedge clk) disable iff (!rstN)
    evtSet[SRC_WAKE] |=> wakeReq);

  p_wake_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    !evtSet[SRC_WAKE] |=> !wakeReq);
endmodule

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
  localparam time CLK_PER = 20ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evtSet = '0, evtCond = '0, regMask = '0, regData = '0;
  logic       regWrEn = 1'b0, regModify = 1'b0, regSel = 1'b0;
  logic [7:0] regRdData;
  logic       irqN, wakeReq;
  logic [2:0] irqCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] enM = '0, flM = '0;
  logic       wakeM = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk(clk), .rstN(rstN), .evtSet(evtSet), .evtCond(evtCond),
    .regWrEn(regWrEn), .regModify(regModify), .regSel(regSel),
    .regMask(regMask), .regData(regData), .regRdData(regRdData),
    .irqN(irqN), .irqCode(irqCode), .wakeReq(wakeReq)
  );

  function automatic logic [2:0] expCode(logic [7:0] en, logic [7:0] fl);
    for (int i = 0; i < 7; i++) if (en[i] && fl[i]) return 3'(i + 1);
    return 3'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " irqN"}, 32'(irqN), 32'(~|(enM & flM)));
    check({tag, " code"}, 32'(irqCode), 32'(expCode(enM, flM)));
    check({tag, " readback R11"}, 32'(regRdData), 32'(regSel ? flM : enM));
    check({tag, " wake R10"}, 32'(wakeReq), 32'(wakeM));
  endtask

  // Drive one cycle of stimulus just after a falling edge, update the model
  // at the rising edge, compare at the next falling edge.
  task automatic step(input logic [7:0] e, input logic [7:0] c, input logic we,
                      input logic mod, input logic sel, input logic [7:0] mk,
                      input logic [7:0] d, input string tag);
    logic [7:0] m;
    evtSet = e; evtCond = c; regWrEn = we; regModify = mod;
    regSel = sel; regMask = mk; regData = d;
    @(posedge clk);
    m = mod ? mk : 8'hFF;
    if (we && !sel) enM = (enM & ~m) | (d & m);
    for (int i = 0; i < 8; i++) begin
      if (e[i]) flM[i] = 1'b1;
      else if (we && sel && m[i]) flM[i] = d[i] | c[i];
    end
    wakeM = e[1];
    @(negedge clk);
    checkAll(tag);
    evtSet = '0; regWrEn = 1'b0;
  endtask

  task automatic idle(input logic sel, input string tag);
    step(8'h00, 8'h00, 1'b0, 1'b0, sel, 8'h00, 8'h00, tag);
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irqN", 32'(irqN), 32'd1);
    check("R1 code", 32'(irqCode), 32'd0);
    regSel = 1'b0; #1;
    check("R1 enable", 32'(regRdData), 32'd0);
    regSel = 1'b1; #1;
    check("R1 flags", 32'(regRdData), 32'd0);

    // R3: event without enable sets the flag, no request
    step(8'h20, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R3 rx0 unenabled");
    check("R3 flag", 32'(regRdData), 32'h20);
    check("R3 irqN", 32'(irqN), 32'd1);

    // R6 plain write ignores mask: enable everything
    step(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, "R6 plain enable");
    check("R6 plain", 32'(regRdData), 32'hFF);
    // R5: host raises all coded flags
    step(8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h7F, "R5 sw set");
    check("R5 irqN", 32'(irqN), 32'd0);
    check("R7 top", 32'(irqCode), 32'd1);
    // R7 walk: clear lowest bit each time via bit-modify
    for (int b = 0; b < 7; b++) begin
      step(8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 8'(1 << b), 8'h00, "R7 walk");
      check("R7 next code", 32'(irqCode), (b < 6) ? 32'(b + 2) : 32'd0);
    end

    // R8: message error alone
    step(8'h80, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R8 merr");
    check("R8 irqN", 32'(irqN), 32'd0);
    check("R8 code", 32'(irqCode), 32'd0);
    step(8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 8'h80, 8'h00, "R8 clear");
    check("R2 released", 32'(irqN), 32'd1);

    // R4: condition blocks the clear
    step(8'h08, 8'h08, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R4 tx1 set");
    step(8'h00, 8'h08, 1'b1, 1'b1, 1'b1, 8'h08, 8'h00, "R4 blocked");
    check("R4 still set", 32'(regRdData), 32'h08);
    step(8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 8'h08, 8'h00, "R4 cleared");
    check("R4 gone", 32'(regRdData), 32'h00);

    // R9: event in same cycle as clear
    step(8'h40, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R9 rx1 set");
    step(8'h40, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, "R9 race");
    check("R9 kept", 32'(regRdData), 32'h40);
    check("R9 code", 32'(irqCode), 32'd7);

    // R6: modify clears one flag while another event lands
    step(8'h01, 8'h00, 1'b1, 1'b1, 1'b1, 8'h40, 8'h00, "R6 modify");
    check("R6 result", 32'(regRdData), 32'h01);
    // R6 masked enable write
    step(8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 8'h01, 8'h00, "R6 en modify");
    check("R6 en result", 32'(regRdData), 32'hFE);
    check("R2 disabled", 32'(irqN), 32'd1);

    // R10: wake pulse lasts one cycle
    step(8'h02, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R10 wake");
    check("R10 pulse", 32'(wakeReq), 32'd1);
    idle(1'b1, "R10 after");
    check("R10 drop", 32'(wakeReq), 32'd0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] e, c;
      e = '0; c = '0;
      for (int i = 0; i < 8; i++) begin
        e[i] = ($urandom % 10) == 0;
        c[i] = ($urandom % 4) == 0;
      end
      step(e, c, ($urandom % 3) == 0, 1'($urandom), 1'(($urandom % 4) != 0),
           8'($urandom), 8'($urandom), "R2 R7 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule